// File: doc/BRIEF.md
# Modem Status Delta Tracker

This block holds the modem status byte of a 16450-style serial port. Four incoming handshake lines arrive already synchronised: clear-to-send, data-set-ready, ring indicator and carrier detect. The block registers their present levels in the upper half of the byte. It latches every qualifying change of a line in a sticky flag in the lower half. While any flag is set and the modem-status interrupt is enabled, it raises an interrupt request.

Software reads the byte with a one-cycle read strobe. The byte shown in the strobe cycle is the one returned. All four change flags clear in the following cycle, but a change that arrives in that same cycle is still recorded.

When the loopback control bit is set, the external lines are ignored. The port's own control outputs then feed the four status inputs. The data-terminal-ready and request-to-send pins that leave the chip are held inactive while loopback is on.

Top module: `msr_tracker`

## Requirements
- R1: Status bit 4 shows the CTS level, bit 5 DSR, bit 6 RI and bit 7 DCD, one clock after the selected source line changes (1 = active).
- R2: Status bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) set on either edge of their line and stay set until a read clears them.
- R3: Status bit 2 sets only when RI goes from active to inactive; a rising RI leaves it clear.
- R4: While `msr_rd_i` is high the output shows the current byte, and all four change bits are clear one clock later.
- R5: A line change that lands in the same clock as a read sets its change bit after that clock.
- R6: With `mcr_i` bit 4 set, CTS takes `mcr_i` bit 1, DSR takes bit 0, RI takes bit 2 and DCD takes bit 3. The external line inputs then have no effect on the status byte.
- R7: Entering or leaving loopback sets change bits for every line whose selected level differs, under the same rules as R2 and R3.
- R8: `dtr_pin_o` and `rts_pin_o` follow `mcr_i` bits 0 and 1 when loopback is off, and are 0 while `mcr_i` bit 4 is set.
- R9: `irq_o` is 1 exactly while `msi_en_i` is 1 and at least one change bit is set.
- R10: During and right after reset, the status byte is 0x00 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mcr_i | input | 5 | Control bits: 0 DTR, 1 RTS, 2 OP1, 3 OP2, 4 loopback |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| msr_rd_i | input | 1 | One-cycle read strobe for the status byte |
| cts_i | input | 1 | Synchronised clear-to-send, 1 = active |
| dsr_i | input | 1 | Synchronised data-set-ready, 1 = active |
| ri_i | input | 1 | Synchronised ring indicator, 1 = active |
| dcd_i | input | 1 | Synchronised carrier detect, 1 = active |
| msr_o | output | 8 | Status byte: levels in bits 7:4, change flags in bits 3:0 |
| irq_o | output | 1 | Modem-status interrupt request |
| dtr_pin_o | output | 1 | Data-terminal-ready to the outside, gated by loopback |
| rts_pin_o | output | 1 | Request-to-send to the outside, gated by loopback |

## Verification
The assertions assume that the line inputs and the control bits are clean, synchronous signals that change only between clock edges. They also assume that the read strobe is a plain level, sampled once per edge. The bench drives every input on the falling edge and samples outputs on the next falling edge, so each input holds steady across the rising edge that captures it. Lines are held inactive during reset, so no change flag is set on the first edge. Lines are also changed together with the read strobe, to test the case where a change and a read coincide.

// File: rtl/msr_pkg.sv
// Package: shared widths and line positions for the modem status tracker.
// Assumes the four-line order below is the order of the status byte nibbles.
package msr_pkg;
    localparam int NLINES  = 4;
    localparam int CTL_W   = 5;
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;
    localparam int CTL_DTR = 0;
    localparam int CTL_RTS = 1;
    localparam int CTL_OP1 = 2;
    localparam int CTL_OP2 = 3;
    localparam int CTL_LPB = 4;
    typedef logic [NLINES-1:0] line_vec_t;
endpackage

// File: rtl/msr_src_mux.sv
// Module: chooses the source of each status line (external or looped-back
// control output) and gates the outgoing DTR/RTS pins.
// Assumes mcr_i is a registered control value, stable between edges.
module msr_src_mux
    import msr_pkg::*;
(
    input  logic [CTL_W-1:0] mcr_i,
    input  line_vec_t        ext_i,
    output line_vec_t        src_o,
    output logic             dtr_pin_o,
    output logic             rts_pin_o
);
    line_vec_t loop_vec;

    // Route each control output onto its looped-back status line.
    always_comb begin
        loop_vec          = '0;
        loop_vec[IDX_CTS] = mcr_i[CTL_RTS];
        loop_vec[IDX_DSR] = mcr_i[CTL_DTR];
        loop_vec[IDX_RI]  = mcr_i[CTL_OP1];
        loop_vec[IDX_DCD] = mcr_i[CTL_OP2];
    end

    // Pick loopback or external lines; silence outgoing pins in loopback.
    always_comb begin
        src_o     = mcr_i[CTL_LPB] ? loop_vec : ext_i;
        dtr_pin_o = mcr_i[CTL_DTR] & ~mcr_i[CTL_LPB];
        rts_pin_o = mcr_i[CTL_RTS] & ~mcr_i[CTL_LPB];
    end

    // Immediate check: no outgoing handshake pin is active in loopback.
    always_comb begin
        if (mcr_i[CTL_LPB]) begin
            p_pins_quiet_r8: assert (!dtr_pin_o && !rts_pin_o)
                else $error("outgoing pins active during loopback");
        end
    end
endmodule

// File: rtl/msr_line_cell.sv
// Module: one status line. Registers the level and latches a sticky change
// flag. TRAIL_ONLY restricts the flag to active-to-inactive transitions.
// Assumes clr_i is a one-cycle read strobe; a change in that cycle survives.
module msr_line_cell #(
    parameter bit TRAIL_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic clr_i,
    output logic level_o,
    output logic delta_o
);
    logic level_q;
    logic delta_q;
    logic hit;

    // Detect a qualifying transition between stored and incoming level.
    always_comb begin
        if (TRAIL_ONLY) hit = level_q & ~src_i;
        else            hit = level_q ^ src_i;
    end

    // Track the level and keep the change flag until a read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            delta_q <= 1'b0;
        end else begin
            level_q <= src_i;
            delta_q <= (delta_q & ~clr_i) | hit;
        end
    end

    assign level_o = level_q;
    assign delta_o = delta_q;

    p_level_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (level_o == $past(src_i)));

    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_i != level_o) && (!TRAIL_ONLY || level_o)) |=> delta_o);

    p_rise_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (TRAIL_ONLY && !level_o && src_i && (!delta_o || clr_i)) |=> !delta_o);
endmodule

// File: rtl/msr_tracker.sv
// Module: modem status byte keeper. Combines the source selector and one
// line cell per handshake line, assembles the byte and the interrupt request.
// Assumes line inputs are already synchronised to clk.
module msr_tracker
    import msr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] mcr_i,
    input  logic             msi_en_i,
    input  logic             msr_rd_i,
    input  logic             cts_i,
    input  logic             dsr_i,
    input  logic             ri_i,
    input  logic             dcd_i,
    output logic [2*NLINES-1:0] msr_o,
    output logic             irq_o,
    output logic             dtr_pin_o,
    output logic             rts_pin_o
);
    line_vec_t ext_w;
    line_vec_t src_w;
    line_vec_t lvl_w;
    line_vec_t dlt_w;

    // Gather the external lines in status order.
    always_comb begin
        ext_w          = '0;
        ext_w[IDX_CTS] = cts_i;
        ext_w[IDX_DSR] = dsr_i;
        ext_w[IDX_RI]  = ri_i;
        ext_w[IDX_DCD] = dcd_i;
    end

    msr_src_mux i_src_mux (
        .mcr_i     (mcr_i),
        .ext_i     (ext_w),
        .src_o     (src_w),
        .dtr_pin_o (dtr_pin_o),
        .rts_pin_o (rts_pin_o)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        msr_line_cell #(
            .TRAIL_ONLY (g == IDX_RI)
        ) i_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_w[g]),
            .clr_i   (msr_rd_i),
            .level_o (lvl_w[g]),
            .delta_o (dlt_w[g])
        );
    end

    // Assemble the byte and the modem-status request.
    always_comb begin
        msr_o = {lvl_w, dlt_w};
        irq_o = msi_en_i & (|dlt_w);
    end

    p_rd_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd_i && (src_w == lvl_w)) |=> (dlt_w == '0));

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !msr_rd_i && msi_en_i) |=> (irq_o || !msi_en_i));
endmodule

// File: tb/test_msr_tracker.sv
// Bench: directed scenarios, one task each, every task checks its results.
module test_msr_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] mcr = '0;
    logic       msi_en = 1'b0;
    logic       rd = 1'b0;
    logic       cts = 1'b0, dsr = 1'b0, ri = 1'b0, dcd = 1'b0;
    logic [7:0] msr;
    logic       irq, dtr_pin, rts_pin;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    msr_tracker i_msr_tracker (
        .clk(clk), .rst_n(rst_n), .mcr_i(mcr), .msi_en_i(msi_en),
        .msr_rd_i(rd), .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd),
        .msr_o(msr), .irq_o(irq), .dtr_pin_o(dtr_pin), .rts_pin_o(rts_pin)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One rising edge, landing on the next falling edge.
    task automatic step();
        @(negedge clk);
    endtask

    // Read strobe for one cycle: check the byte shown, then after the edge.
    task automatic do_read(input string req, input logic [7:0] seen, input logic [7:0] after);
        rd = 1'b1;
        #1 chk(req, msr, seen);
        step();
        rd = 1'b0;
        #1 chk(req, msr, after);
    endtask

    task automatic t_reset();
        repeat (3) step();
        chk("R10 byte in reset", msr, 8'h00);
        chk("R10 irq in reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        msi_en = 1'b1;
        step();
        chk("R10 byte after reset", msr, 8'h00);
        chk("R10 irq after reset", {7'd0, irq}, 8'h00);
        chk("R8 pins idle", {6'd0, dtr_pin, rts_pin}, 8'h00);
    endtask

    task automatic t_edges();
        cts = 1'b1; step();
        chk("R1 R2 cts rise", msr, 8'h11);
        chk("R9 irq set", {7'd0, irq}, 8'h01);
        do_read("R4 read clears", 8'h11, 8'h10);
        chk("R9 irq cleared", {7'd0, irq}, 8'h00);
        cts = 1'b0; dsr = 1'b1; dcd = 1'b1; step();
        chk("R2 multi edges", msr, 8'hAB);
        step();
        chk("R4 flags hold", msr, 8'hAB);
        do_read("R4 second read", 8'hAB, 8'hA0);
    endtask

    task automatic t_ring();
        ri = 1'b1; step();
        chk("R3 ri rise no flag", msr, 8'hE0);
        chk("R3 no irq on rise", {7'd0, irq}, 8'h00);
        ri = 1'b0; step();
        chk("R3 ri fall flags", msr, 8'hA4);
        do_read("R3 clear", 8'hA4, 8'hA0);
    endtask

    task automatic t_coincide();
        dcd = 1'b0;
        do_read("R5 change with read", 8'hA0, 8'h28);
        chk("R5 irq kept", {7'd0, irq}, 8'h01);
        do_read("R5 clear", 8'h28, 8'h20);
    endtask

    task automatic t_enable();
        msi_en = 1'b0; dsr = 1'b0; step();
        chk("R9 flag without enable", msr, 8'h02);
        chk("R9 irq masked", {7'd0, irq}, 8'h00);
        msi_en = 1'b1;
        #1 chk("R9 irq on enable", {7'd0, irq}, 8'h01);
        step();
        do_read("R9 clear", 8'h02, 8'h00);
    endtask

    task automatic t_loop();
        mcr = 5'h03; step();
        chk("R8 pins follow", {6'd0, dtr_pin, rts_pin}, 8'h03);
        chk("R6 no loop no change", msr, 8'h00);
        mcr = 5'h13; step();
        chk("R7 enter loopback", msr, 8'h33);
        chk("R8 pins forced off", {6'd0, dtr_pin, rts_pin}, 8'h00);
        do_read("R6 clear", 8'h33, 8'h30);
        dcd = 1'b1; ri = 1'b1; step();
        chk("R6 external ignored", msr, 8'h30);
        mcr = 5'h1C; step();
        chk("R6 op bits looped", msr, 8'hCB);
        do_read("R6 clear 2", 8'hCB, 8'hC0);
        dcd = 1'b0; ri = 1'b0; step();
        chk("R6 external ignored 2", msr, 8'hC0);
        mcr = 5'h00; step();
        chk("R7 leave loopback", msr, 8'h0C);
        do_read("R7 clear", 8'h0C, 8'h00);
    endtask

    initial begin
        step();
        t_reset();
        t_edges();
        t_ring();
        t_coincide();
        t_enable();
        t_loop();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule